// File: doc/BRIEF.md
# UART Modem Handshake Controller

This block owns the RTS/CTS handshake of a serial port. It drives the RTS pin and samples the CTS pin, and each pin has its own choice of active level. RTS can be driven by hand from a software control bit. It can also be withdrawn automatically when the receive FIFO holds as many bytes as a programmable level. The CTS pin is synchronised, and any change of level on it is caught in a sticky flag. Software clears that flag by writing 1, and the flag can raise a modem interrupt.

With automatic CTS enabled, the block gates the transmitter's per-character start request. A character is only allowed to begin while CTS sits at its active level. The permit is consulted only at a character boundary, so a frame already under way is never cut short. The serial shifters, the FIFOs and the register bus lie outside the block. Configuration arrives as one control word with a write enable, and the flag clear arrives as a one-bit write with its own enable.

Top module: `modem_flow_ctrl`

## Requirements
- R1: The control word holds: bit 0 `rts_on` (software RTS request), bit 1 `rts_hi` (RTS polarity), bit 2 `cts_hi` (CTS polarity), bit 3 `auto_rts`, bit 4 `auto_cts`, bit 5 `mdm_ie` and bits 9:6 `rts_lvl`. A word written with `ctrl_we_i` takes effect on the next clock edge. With `auto_rts`=0, `rts_pin_o` shows the active level when `rts_on`=1 and the inactive level when `rts_on`=0, one clock edge after the word takes effect.
- R2: For RTS, a polarity bit of 0 means active low (active level 0) and 1 means active high (active level 1). `cts_hi` uses the same encoding for the CTS pin.
- R3: With `auto_rts`=1 and `rts_on`=1, RTS is driven inactive while the receive count is at or above `rts_lvl`, and active again once the count falls below it. A level of 0 therefore holds RTS inactive. The pin follows a count change one clock edge later.
- R4: `tx_permit_o` is high only while `tx_start_req_i` is high. With `auto_cts`=0 it equals `tx_start_req_i`. With `auto_cts`=1 it is additionally gated by the synchronised CTS being at its active level. The transmitter samples the permit only when starting a character.
- R5: The CTS pin passes through two flip-flops. `cts_state_o` shows the pin level two clock edges after the pin changes. `cts_chg_o` is set on the edge after that.
- R6: `cts_chg_o` stays set until a write with `stat_we_i`=1 and `stat_wdata_i`=1 clears it on the next edge. A write of 0 has no effect. A change detected in the same cycle as a clear leaves the flag set.
- R7: `mdm_irq_o` equals `cts_chg_o` AND `mdm_ie`.
- R8: After reset, the control word is all zero, `rts_pin_o` is 1 (inactive for active-low), and `cts_chg_o` and `mdm_irq_o` are 0. The CTS synchroniser resets to the idle level 1, so no change is reported for a pin held high.
- R9: `rts_state_o` always reports the level currently driven on `rts_pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_pin_i | input | 1 | CTS pin, asynchronous |
| rx_count_i | input | CNT_W | Receive FIFO byte count |
| tx_start_req_i | input | 1 | Transmitter wants to start a character |
| ctrl_we_i | input | 1 | Control word write enable |
| ctrl_wdata_i | input | 10 | Control word (fields in R1) |
| stat_we_i | input | 1 | Status write enable |
| stat_wdata_i | input | 1 | Write 1 to clear the CTS change flag |
| rts_pin_o | output | 1 | RTS pin |
| tx_permit_o | output | 1 | Character start granted |
| rts_state_o | output | 1 | RTS pin level, read-only status |
| cts_state_o | output | 1 | Synchronised CTS pin level, read-only status |
| cts_chg_o | output | 1 | Sticky CTS change flag |
| mdm_irq_o | output | 1 | Modem interrupt |

## Verification
The assertions watch, on every cycle:
- that the permit never appears without a request, nor against an inactive CTS while auto gating is on;
- that the change flag stays sticky until it is cleared;
- that a new synchronised CTS level always raises the flag;
- that RTS goes inactive under the automatic level condition;
- that the interrupt never fires without the flag.

Only the bench scenarios show the exact latencies: the two-edge synchroniser and the one-edge RTS update. They also show the polarity mapping over random control words and counts, set-beats-clear ordering, and that a clear write of 0 changes nothing.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    localparam int LVL_W  = 4;
    localparam int CTRL_W = 6 + LVL_W;

    // Control word, MSB first: level, then flags down to bit 0
    typedef struct packed {
        logic [LVL_W-1:0] rts_lvl;
        logic             mdm_ie;
        logic             auto_cts;
        logic             auto_rts;
        logic             cts_hi;
        logic             rts_hi;
        logic             rts_on;
    } cfg_t;
endpackage

// File: rtl/mfc_cts_mon.sv
module mfc_cts_mon #(
    parameter int   SYNC_STAGES = 2,
    parameter logic CTS_IDLE    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_pin_i,
    input  logic clr_i,
    output logic cts_lvl_o,
    output logic chg_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   chg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[LAST-1:0], cts_pin_i};
        st_d.prev = st_q.sync[LAST];
        if (st_q.sync[LAST] != st_q.prev) begin
            st_d.chg = 1'b1;
        end else if (clr_i) begin
            st_d.chg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= {SYNC_STAGES{CTS_IDLE}};
            st_q.prev <= CTS_IDLE;
            st_q.chg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cts_lvl_o = st_q.sync[LAST];
    assign chg_o     = st_q.chg;
endmodule

// File: rtl/mfc_rts_drv.sv
module mfc_rts_drv #(
    parameter int CNT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mfc_pkg::cfg_t   cfg_i,
    input  logic [CNT_W-1:0] rx_count_i,
    output logic            rts_pin_o
);
    typedef struct packed {
        logic pin;
    } st_t;

    st_t  st_d, st_q;
    logic at_level;
    logic drive_on;

    always_comb begin
        st_d     = st_q;
        at_level = int'(rx_count_i) >= int'(cfg_i.rts_lvl);
        drive_on = cfg_i.rts_on && !(cfg_i.auto_rts && at_level);
        st_d.pin = drive_on ? cfg_i.rts_hi : ~cfg_i.rts_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pin <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_pin_o = st_q.pin;
endmodule

// File: rtl/modem_flow_ctrl.sv
module modem_flow_ctrl #(
    parameter int   CNT_W       = 6,
    parameter int   SYNC_STAGES = 2,
    parameter logic CTS_IDLE    = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cts_pin_i,
    input  logic [CNT_W-1:0]           rx_count_i,
    input  logic                       tx_start_req_i,
    input  logic                       ctrl_we_i,
    input  logic [mfc_pkg::CTRL_W-1:0] ctrl_wdata_i,
    input  logic                       stat_we_i,
    input  logic                       stat_wdata_i,
    output logic                       rts_pin_o,
    output logic                       tx_permit_o,
    output logic                       rts_state_o,
    output logic                       cts_state_o,
    output logic                       cts_chg_o,
    output logic                       mdm_irq_o
);
    mfc_pkg::cfg_t cfg_d, cfg_q;
    logic          cts_lvl;
    logic          cts_active;
    logic          chg;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_we_i) begin
            cfg_d = mfc_pkg::cfg_t'(ctrl_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    mfc_cts_mon #(
        .SYNC_STAGES (SYNC_STAGES),
        .CTS_IDLE    (CTS_IDLE)
    ) u_cts (
        .clk       (clk),
        .rst_n     (rst_n),
        .cts_pin_i (cts_pin_i),
        .clr_i     (stat_we_i && stat_wdata_i),
        .cts_lvl_o (cts_lvl),
        .chg_o     (chg)
    );

    mfc_rts_drv #(
        .CNT_W (CNT_W)
    ) u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg_q),
        .rx_count_i (rx_count_i),
        .rts_pin_o  (rts_pin_o)
    );

    assign cts_active  = (cts_lvl == cfg_q.cts_hi);
    assign tx_permit_o = tx_start_req_i && (!cfg_q.auto_cts || cts_active);
    assign rts_state_o = rts_pin_o;
    assign cts_state_o = cts_lvl;
    assign cts_chg_o   = chg;
    assign mdm_irq_o   = chg && cfg_q.mdm_ie;
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_start_req_i,
    input logic             stat_we_i,
    input logic             stat_wdata_i,
    input logic [CNT_W-1:0] rx_count_i,
    input mfc_pkg::cfg_t    cfg,
    input logic             rts_pin_o,
    input logic             tx_permit_o,
    input logic             cts_state_o,
    input logic             cts_chg_o,
    input logic             mdm_irq_o
);
    logic full_hit;
    assign full_hit = cfg.rts_on && cfg.auto_rts && (int'(rx_count_i) >= int'(cfg.rts_lvl));

    // R4: no permit without a request
    a_r4_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_permit_o |-> tx_start_req_i);

    // R4: automatic gating blocks an inactive CTS
    a_r4_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_permit_o && cfg.auto_cts) |-> (cts_state_o == cfg.cts_hi));

    // R5: a new synchronised CTS level raises the flag
    a_r5_chg_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_state_o != $past(cts_state_o)) |=> cts_chg_o);

    // R6: flag holds until a clear write of 1
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_chg_o && !(stat_we_i && stat_wdata_i)) |=> cts_chg_o);

    // R3: automatic level condition drives RTS inactive
    a_r3_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
        full_hit |=> (rts_pin_o == ~$past(cfg.rts_hi)));

    // R7: interrupt needs the flag
    a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        mdm_irq_o |-> cts_chg_o);
endmodule

bind modem_flow_ctrl mfc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_start_req_i (tx_start_req_i),
    .stat_we_i      (stat_we_i),
    .stat_wdata_i   (stat_wdata_i),
    .rx_count_i     (rx_count_i),
    .cfg            (cfg_q),
    .rts_pin_o      (rts_pin_o),
    .tx_permit_o    (tx_permit_o),
    .cts_state_o    (cts_state_o),
    .cts_chg_o      (cts_chg_o),
    .mdm_irq_o      (mdm_irq_o)
);

// File: tb/sim_modem_flow_ctrl.sv
module sim_modem_flow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int CW         = mfc_pkg::CTRL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cts_pin = 1'b1;
    logic [CNT_W-1:0] rx_count = '0;
    logic             tx_req = 1'b0;
    logic             ctrl_we = 1'b0;
    logic [CW-1:0]    ctrl_wdata = '0;
    logic             stat_we = 1'b0;
    logic             stat_wdata = 1'b0;
    logic rts_pin, tx_permit, rts_state, cts_state, cts_chg, mdm_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [CW-1:0] cur_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_flow_ctrl #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cts_pin_i(cts_pin), .rx_count_i(rx_count),
        .tx_start_req_i(tx_req), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
        .stat_we_i(stat_we), .stat_wdata_i(stat_wdata), .rts_pin_o(rts_pin),
        .tx_permit_o(tx_permit), .rts_state_o(rts_state), .cts_state_o(cts_state),
        .cts_chg_o(cts_chg), .mdm_irq_o(mdm_irq)
    );

    // Bench model of the RTS pin (R1, R2, R3)
    function automatic logic rts_exp(logic [CW-1:0] w, logic [CNT_W-1:0] cnt);
        logic on;
        on = w[0] && !(w[3] && (int'(cnt) >= int'(w[9:6])));
        return on ? w[1] : ~w[1];
    endfunction

    // Bench model of the permit (R4)
    function automatic logic permit_exp(logic [CW-1:0] w, logic req, logic cts);
        return req && (!w[4] || (cts == w[2]));
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(logic [CW-1:0] w);
        ctrl_we = 1'b1; ctrl_wdata = w; cur_word = w;
        tick(1);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_stat(logic b);
        stat_we = 1'b1; stat_wdata = b;
        tick(1);
        stat_we = 1'b0; stat_wdata = 1'b0;
    endtask

    initial begin
        process_seed();
        tick(3);
        // R8: reset state
        check("R8 rts", rts_pin, 1'b1);
        check("R8 chg", cts_chg, 1'b0);
        check("R8 irq", mdm_irq, 1'b0);
        rst_n = 1'b1;
        tick(4);
        check("R8 no false change", cts_chg, 1'b0);
        check("R9 rts state", rts_state, 1'b1);

        // R1/R2: manual RTS, active high then active low
        wr_ctrl(10'b0000_000011); tick(1);
        check("R1 on hi", rts_pin, 1'b1);
        wr_ctrl(10'b0000_000001); tick(1);
        check("R2 on lo", rts_pin, 1'b0);
        check("R9 state", rts_state, 1'b0);
        wr_ctrl(10'b0000_000000); tick(1);
        check("R1 off lo", rts_pin, 1'b1);

        // R3: auto RTS at level 5, active high
        wr_ctrl({4'd5, 6'b001011}); rx_count = 6'd4; tick(1);
        check("R3 below", rts_pin, 1'b1);
        rx_count = 6'd5; tick(1);
        check("R3 equal", rts_pin, 1'b0);
        rx_count = 6'd9; tick(1);
        check("R3 above", rts_pin, 1'b0);
        rx_count = 6'd4; tick(1);
        check("R3 back below", rts_pin, 1'b1);
        wr_ctrl({4'd0, 6'b001011}); rx_count = 6'd0; tick(1);
        check("R3 level zero", rts_pin, 1'b0);

        // R4: auto CTS, active low; pin currently 1 (inactive)
        wr_ctrl(10'b0000_010000); tx_req = 1'b1; tick(1);
        check("R4 gated", tx_permit, 1'b0);
        cts_pin = 1'b0; tick(1);
        check("R5 sync one edge", cts_state, 1'b1);
        tick(1);
        check("R5 sync two edges", cts_state, 1'b0);
        check("R4 granted", tx_permit, 1'b1);
        check("R5 flag not yet", cts_chg, 1'b0);
        tick(1);
        check("R5 flag set", cts_chg, 1'b1);
        tx_req = 1'b0; #1;
        check("R4 no req", tx_permit, 1'b0);

        // R6: write 0 does nothing, write 1 clears
        wr_stat(1'b0);
        check("R6 write zero", cts_chg, 1'b1);
        wr_stat(1'b1);
        check("R6 cleared", cts_chg, 1'b0);

        // R6: set wins over clear in the same cycle
        cts_pin = 1'b1; tick(2);
        stat_we = 1'b1; stat_wdata = 1'b1; tick(1);
        stat_we = 1'b0; stat_wdata = 1'b0;
        check("R6 set beats clear", cts_chg, 1'b1);

        // R7: interrupt enable
        check("R7 masked", mdm_irq, 1'b0);
        wr_ctrl(10'b0000_100000); #1;
        check("R7 enabled", mdm_irq, 1'b1);
        wr_stat(1'b1);
        check("R7 cleared", mdm_irq, 1'b0);

        // Random: control words and counts (R1, R2, R3, R4, R9)
        for (int i = 0; i < 200; i++) begin
            logic [CW-1:0] w;
            w = CW'($urandom);
            wr_ctrl(w);
            rx_count = CNT_W'($urandom_range(0, 20));
            tx_req = 1'($urandom);
            tick(1);
            check("R3 random rts", rts_pin, rts_exp(w, rx_count));
            check("R9 random state", rts_state, rts_pin);
            check("R4 random permit", tx_permit, permit_exp(w, tx_req, cts_pin));
        end
        tx_req = 1'b0;

        // Random CTS activity (R5, R6, R7)
        wr_ctrl(10'b0000_100000);
        for (int i = 0; i < 60; i++) begin
            logic nv, old;
            old = cts_pin;
            nv = 1'($urandom);
            cts_pin = nv;
            tick(4);
            check("R5 random level", cts_state, nv);
            check("R5 random flag", cts_chg, nv != old);
            check("R7 random irq", mdm_irq, nv != old);
            wr_stat(1'b1);
            check("R6 random clear", cts_chg, 1'b0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic process_seed();
        int unsigned s;
        s = $urandom(32'd20240611);
        s = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule